// File: doc/BRIEF.md
# Configurable UART receive engine

This block is an asynchronous serial receiver. It watches one serial line, finds the start of each character, samples every bit near its centre and presents the finished character on a small parallel read port. The port has a data-valid flag, a ninth-bit output and three error flags, and the reader clears them with a one-cycle acknowledge strobe.

Runtime controls set the character format. Three bits select a frame of 8, 9 or 10 bits, with or without parity. A fourth control selects LSB-first or MSB-first reception, and the stored word is aligned the same way in both cases. The line polarity can be inverted. The input can also come from one of two transmitter-side sources in place of the receive pin. The block makes its own 16x sampling tick from a 13-bit integer divisor and a 5-bit fractional adjust.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset `rd_valid_o`, `rd_bit8_o`, `rd_data_o` and all three error flags are 0.
- R2: The frame length is 10 bits when `cfg_ten_i` and `cfg_par_en_i` are both 1. Otherwise it is 9 bits when `cfg_nine_i` is 1 and 8 bits when it is 0. `cfg_ten_i` has no effect when parity is off. The number of data bits is the frame length minus 1 when parity is on, which gives 7, 8 or 9 data bits. Data bits 7..0 appear on `rd_data_o`, and bits above the data width read as 0.
- R3: With 9 data bits, data bit 8 appears on `rd_bit8_o`. With 7 or 8 data bits, `rd_bit8_o` is 0.
- R4: When `cfg_msb_first_i` is 1, the first bit after the start bit is the highest data bit and the bit just before the parity bit (or before the stop bit when parity is off) is bit 0. The word on `rd_data_o`/`rd_bit8_o` has the same alignment in both orders.
- R5: Each bit value is the majority of samples 7, 8 and 9 of its 16 sample periods. A falling edge whose start bit reads high by that vote returns the receiver to idle with no flag and no data.
- R6: A stop bit that reads low sets `rd_frame_err_o`. With parity on, a parity bit that differs from the expected value sets `rd_parity_err_o`. The expected value makes the count of ones even when `cfg_par_odd_i` is 0 and odd when it is 1.
- R7: A cycle with `rd_ack_i` high clears `rd_valid_o` and all three error flags on the next edge, unless a character completes in that same cycle.
- R8: A character that completes while `rd_valid_o` is 1 and no acknowledge is given sets `rd_overrun_o`. The stored data, ninth bit and error flags are left unchanged.
- R9: A sample period lasts `cfg_div_i` clocks. On `cfg_frac_i` of every 32 periods it lasts one clock more, and these longer periods are spread evenly. A divisor of 0 stops sampling, and then no character is received.
- R10: When `cfg_inv_i` is 1, the selected input is inverted before start detection, so the line idles low and a rising edge begins a character.
- R11: When `cfg_loop_i` is 0 the input is `rxd_i`. When it is 1 the input is `tx_loop_i` if `cfg_loop_src_i` is 0 and `txd_pin_i` if it is 1. An input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive pin |
| tx_loop_i | input | 1 | Transmitter serial output, internal loop source |
| txd_pin_i | input | 1 | Transmit pin readback, single-wire loop source |
| cfg_div_i | input | 13 | Integer clock divisor for the 16x sample tick |
| cfg_frac_i | input | 5 | Fractional adjust, extra clocks per 32 sample periods |
| cfg_nine_i | input | 1 | Nine-bit frame select |
| cfg_ten_i | input | 1 | Ten-bit frame select (only with parity) |
| cfg_par_en_i | input | 1 | Parity enable |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_msb_first_i | input | 1 | MSB-first reception |
| cfg_inv_i | input | 1 | Invert serial input polarity |
| cfg_loop_i | input | 1 | Take input from a transmitter-side source |
| cfg_loop_src_i | input | 1 | Loop source select: 0 internal, 1 transmit pin |
| rd_ack_i | input | 1 | Read acknowledge strobe |
| rd_data_o | output | 8 | Received data bits 7..0 |
| rd_bit8_o | output | 1 | Received data bit 8 |
| rd_valid_o | output | 1 | Unread character present |
| rd_frame_err_o | output | 1 | Framing error for the stored character |
| rd_parity_err_o | output | 1 | Parity error for the stored character |
| rd_overrun_o | output | 1 | A character was lost while data was unread |

## Verification
Every cycle, the assertions check how the read port behaves over time. An acknowledge clears the valid flag. Unread data stays stable. The overrun and error flags are never set without valid data. A completed character always raises valid. The sample tick never fires while the divisor is 0, and back-to-back ticks are impossible when the divisor is 2 or more. The bench scenarios are the only place where the decoded values can be shown correct. These cover the frame-length table, bit-order normalisation, parity and framing errors, start-glitch rejection, fractional baud accuracy over whole frames, polarity inversion and input source selection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int RX_OSR      = 16;  // samples per bit
    localparam int RX_DATA_MAX = 9;   // widest data word
    localparam int RX_BYTE_W   = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W  = 13,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              tick_o
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              ext;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic [CNT_W-1:0]  period;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        st_d    = st_q;
        period  = {1'b0, div_i} + CNT_W'(st_q.ext);
        acc_sum = {1'b0, st_q.acc} + {1'b0, frac_i};
        tick_o  = (div_i != '0) && (st_q.cnt >= period);
        if (div_i == '0) begin
            st_d.cnt = CNT_W'(1);
            st_d.acc = '0;
            st_d.ext = 1'b0;
        end else if (tick_o) begin
            // carry out of the accumulator lengthens the next period
            st_d.cnt = CNT_W'(1);
            st_d.acc = acc_sum[FRAC_W-1:0];
            st_d.ext = acc_sum[FRAC_W];
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(1);
            st_q.acc <= '0;
            st_q.ext <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic tx_loop_i,
    input  logic txd_pin_i,
    input  logic loop_i,
    input  logic loop_src_i,
    input  logic inv_i,
    output logic line_o
);
    logic                   raw;
    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    always_comb begin
        if (!loop_i)        raw = rxd_i;
        else if (loop_src_i) raw = txd_pin_i;
        else                raw = tx_loop_i;
        sync_d[0] = raw ^ inv_i;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_comb sync_d[g] = sync_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR      = RX_OSR,
    parameter int DATA_MAX = RX_DATA_MAX,
    parameter int BYTE_W   = RX_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              nine_i,
    input  logic              ten_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              msb_first_i,
    input  logic              rd_ack_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              bit8_o,
    output logic              valid_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              overrun_o,
    output logic              done_o
);
    localparam int PH_W = $clog2(OSR);
    localparam int NB_W = $clog2(DATA_MAX + 1);
    localparam logic [PH_W-1:0] PH_V0   = PH_W'(OSR/2 - 2);
    localparam logic [PH_W-1:0] PH_V1   = PH_W'(OSR/2 - 1);
    localparam logic [PH_W-1:0] PH_V2   = PH_W'(OSR/2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [PH_W-1:0]     ph;
        logic [1:0]          votes;
        logic [NB_W-1:0]     nbit;
        logic [DATA_MAX-1:0] sh;
        logic                pbit;
        logic                prev;
        logic [BYTE_W-1:0]   data;
        logic                b8;
        logic                valid;
        logic                fe;
        logic                pe;
        logic                ov;
    } core_st_t;

    core_st_t q, n;

    logic [NB_W-1:0]     ndata;
    logic [DATA_MAX-1:0] mask, word;
    logic                bit_v, par_exp;

    always_comb begin
        // data width from the three format controls
        if (ten_i && par_en_i) ndata = NB_W'(9);
        else if (nine_i)       ndata = par_en_i ? NB_W'(8) : NB_W'(9);
        else                   ndata = par_en_i ? NB_W'(7) : NB_W'(8);
        mask    = DATA_MAX'((DATA_MAX+1)'(1) << ndata) - DATA_MAX'(1);
        word    = (msb_first_i ? q.sh : (q.sh >> (NB_W'(DATA_MAX) - ndata))) & mask;
        par_exp = (^word) ^ par_odd_i;
        bit_v   = ({1'b0, q.votes} + {2'b00, line_i}) >= 3'd2;
    end

    always_comb begin
        n      = q;
        done_o = 1'b0;
        if (rd_ack_i) begin
            n.valid = 1'b0;
            n.fe    = 1'b0;
            n.pe    = 1'b0;
            n.ov    = 1'b0;
        end
        if (tick_i) begin
            if (q.st == RX_IDLE) begin
                n.prev = line_i;
                if (q.prev && !line_i) begin
                    n.st    = RX_START;
                    n.ph    = PH_W'(1);
                    n.votes = '0;
                    n.nbit  = '0;
                    n.sh    = '0;
                end
            end else begin
                n.ph = (q.ph == PH_LAST) ? '0 : q.ph + PH_W'(1);
                if (q.ph == PH_V0 || q.ph == PH_V1)
                    n.votes = q.votes + {1'b0, line_i};
                if (q.ph == PH_V2) begin
                    n.votes = '0;
                    case (q.st)
                        RX_START: begin
                            if (bit_v) begin
                                n.st   = RX_IDLE;
                                n.prev = line_i;
                            end else begin
                                n.st = RX_DATA;
                            end
                        end
                        RX_DATA: begin
                            n.sh   = msb_first_i ? {q.sh[DATA_MAX-2:0], bit_v}
                                                 : {bit_v, q.sh[DATA_MAX-1:1]};
                            n.nbit = q.nbit + NB_W'(1);
                            if (q.nbit + NB_W'(1) >= ndata)
                                n.st = par_en_i ? RX_PAR : RX_STOP;
                        end
                        RX_PAR: begin
                            n.pbit = bit_v;
                            n.st   = RX_STOP;
                        end
                        RX_STOP: begin
                            done_o = 1'b1;
                            n.st   = RX_IDLE;
                            n.prev = line_i;
                            if (q.valid && !rd_ack_i) begin
                                n.ov = 1'b1;
                            end else begin
                                n.data  = word[BYTE_W-1:0];
                                n.b8    = (ndata == NB_W'(9)) ? word[8] : 1'b0;
                                n.valid = 1'b1;
                                n.fe    = !bit_v;
                                n.pe    = par_en_i && (q.pbit != par_exp);
                                n.ov    = 1'b0;
                            end
                        end
                        default: n.st = RX_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign data_o       = q.data;
    assign bit8_o       = q.b8;
    assign valid_o      = q.valid;
    assign frame_err_o  = q.fe;
    assign parity_err_o = q.pe;
    assign overrun_o    = q.ov;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 13,
    parameter int FRAC_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tx_loop_i,
    input  logic              txd_pin_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [FRAC_W-1:0] cfg_frac_i,
    input  logic              cfg_nine_i,
    input  logic              cfg_ten_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_msb_first_i,
    input  logic              cfg_inv_i,
    input  logic              cfg_loop_i,
    input  logic              cfg_loop_src_i,
    input  logic              rd_ack_i,
    output logic [RX_BYTE_W-1:0] rd_data_o,
    output logic              rd_bit8_o,
    output logic              rd_valid_o,
    output logic              rd_frame_err_o,
    output logic              rd_parity_err_o,
    output logic              rd_overrun_o
);
    logic baud_tick;
    logic rx_line;
    logic char_done;

    uart_rx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (cfg_div_i),
        .frac_i (cfg_frac_i),
        .tick_o (baud_tick)
    );

    uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_i      (rxd_i),
        .tx_loop_i  (tx_loop_i),
        .txd_pin_i  (txd_pin_i),
        .loop_i     (cfg_loop_i),
        .loop_src_i (cfg_loop_src_i),
        .inv_i      (cfg_inv_i),
        .line_o     (rx_line)
    );

    uart_rx_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (baud_tick),
        .line_i       (rx_line),
        .nine_i       (cfg_nine_i),
        .ten_i        (cfg_ten_i),
        .par_en_i     (cfg_par_en_i),
        .par_odd_i    (cfg_par_odd_i),
        .msb_first_i  (cfg_msb_first_i),
        .rd_ack_i     (rd_ack_i),
        .data_o       (rd_data_o),
        .bit8_o       (rd_bit8_o),
        .valid_o      (rd_valid_o),
        .frame_err_o  (rd_frame_err_o),
        .parity_err_o (rd_parity_err_o),
        .overrun_o    (rd_overrun_o),
        .done_o       (char_done)
    );
endmodule

// File: rtl/uart_rx_engine_chk.sv
module uart_rx_engine_chk #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_ack_i,
    input logic             rd_valid_o,
    input logic [7:0]       rd_data_o,
    input logic             rd_bit8_o,
    input logic             rd_frame_err_o,
    input logic             rd_parity_err_o,
    input logic             rd_overrun_o,
    input logic [DIV_W-1:0] cfg_div_i,
    input logic             baud_tick,
    input logic             char_done
);
    // R7: acknowledge without a completing character empties the port
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i && !char_done |=> !rd_valid_o);

    // R8: unread data is held until acknowledged
    a_r8_unread_held: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ack_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_bit8_o));

    // R8: overrun only alongside unread data
    a_r8_overrun_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_overrun_o |-> rd_valid_o);

    // R8: a completed character always leaves data waiting
    a_r8_done_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rd_valid_o);

    // R6: error flags belong to a stored character
    a_r6_flags_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_err_o || rd_parity_err_o) |-> rd_valid_o);

    // R9: zero divisor stops sampling
    a_r9_div_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_div_i == '0 |-> !baud_tick);

    // R9: sample periods are at least two clocks when the divisor is two or more
    a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick && cfg_div_i >= DIV_W'(2) |=> (cfg_div_i < DIV_W'(2)) || !baud_tick);
endmodule

bind uart_rx_engine uart_rx_engine_chk #(.DIV_W(DIV_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_ack_i        (rd_ack_i),
    .rd_valid_o      (rd_valid_o),
    .rd_data_o       (rd_data_o),
    .rd_bit8_o       (rd_bit8_o),
    .rd_frame_err_o  (rd_frame_err_o),
    .rd_parity_err_o (rd_parity_err_o),
    .rd_overrun_o    (rd_overrun_o),
    .cfg_div_i       (cfg_div_i),
    .baud_tick       (baud_tick),
    .char_done       (char_done)
);

// File: tb/uart_rx_engine_tb.sv
`timescale 1ns/1ps
module uart_rx_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic rxd = 1'b1, txl = 1'b1, txp = 1'b1, ack = 1'b0;
    logic [12:0] g_div = 13'd4;
    logic [4:0]  g_frac = 5'd0;
    logic g_m = 0, g_ten = 0, g_pe = 0, g_odd = 0, g_msb = 0, g_inv = 0;
    int   g_route = 0;
    int   drv_sel = 0;

    logic [7:0] rd_data;
    logic rd_b8, rd_valid, rd_fe, rd_pe, rd_ov;

    int total = 0, failed = 0;
    bit finished = 0;

    uart_rx_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .rxd_i(rxd), .tx_loop_i(txl), .txd_pin_i(txp),
        .cfg_div_i(g_div), .cfg_frac_i(g_frac),
        .cfg_nine_i(g_m), .cfg_ten_i(g_ten), .cfg_par_en_i(g_pe),
        .cfg_par_odd_i(g_odd), .cfg_msb_first_i(g_msb), .cfg_inv_i(g_inv),
        .cfg_loop_i(g_route != 0), .cfg_loop_src_i(g_route == 2),
        .rd_ack_i(ack),
        .rd_data_o(rd_data), .rd_bit8_o(rd_b8), .rd_valid_o(rd_valid),
        .rd_frame_err_o(rd_fe), .rd_parity_err_o(rd_pe), .rd_overrun_o(rd_ov)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ndata();
        if (g_ten && g_pe) return 9;
        if (g_m) return g_pe ? 8 : 9;
        return g_pe ? 7 : 8;
    endfunction

    function automatic int bitlen();
        return 16 * int'(g_div) + int'(g_frac) / 2;
    endfunction

    function automatic logic [8:0] masked(input logic [8:0] w);
        return w & 9'((10'd1 << ndata()) - 10'd1);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input logic v);
        case (drv_sel)
            0: rxd = v ^ g_inv;
            1: txl = v ^ g_inv;
            default: txp = v ^ g_inv;
        endcase
    endtask

    task automatic idle_all();
        rxd = ~g_inv; txl = ~g_inv; txp = ~g_inv;
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic send(input logic [8:0] w, input logic stopv, input logic pflip);
        int nd = ndata();
        int bl = bitlen();
        logic [8:0] mw = masked(w);
        set_line(1'b0); wait_clk(bl);
        for (int i = 0; i < nd; i++) begin
            set_line(mw[g_msb ? nd - 1 - i : i]);
            wait_clk(bl);
        end
        if (g_pe) begin
            set_line((^mw) ^ g_odd ^ pflip);
            wait_clk(bl);
        end
        set_line(stopv); wait_clk(bl);
        set_line(1'b1);  wait_clk(2 * bl);
    endtask

    task automatic expect_char(input string req, input logic [8:0] w,
                               input logic fe, input logic pe, input logic ov);
        logic [8:0] mw = masked(w);
        check({req, " valid"}, rd_valid, 1'b1);
        check({req, " data"},  rd_data, mw[7:0]);
        check({req, " bit8 R3"}, rd_b8, (ndata() == 9) ? mw[8] : 1'b0);
        check({req, " frame R6"}, rd_fe, fe);
        check({req, " parity R6"}, rd_pe, pe);
        check({req, " overrun R8"}, rd_ov, ov);
        pulse_ack();
        @(negedge clk);
        check("R7 ack clears valid", rd_valid, 1'b0);
        check("R7 ack clears flags", {rd_fe, rd_pe, rd_ov}, 3'b000);
    endtask

    task automatic reconfig();
        drv_sel = g_route;
        idle_all();
        wait_clk(3 * bitlen());
        pulse_ack();
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; failed++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        wait_clk(4);
        // R1: reset values
        check("R1 valid", rd_valid, 1'b0);
        check("R1 data", {rd_b8, rd_data}, 9'h000);
        check("R1 flags", {rd_fe, rd_pe, rd_ov}, 3'b000);
        rst_n = 1'b1;
        wait_clk(4);
        reconfig();

        // R2 R4: 8 data bits both orders
        send(9'h0b5, 1'b1, 1'b0); expect_char("R2 8N", 9'h0b5, 0, 0, 0);
        g_msb = 1; reconfig();
        send(9'h0b5, 1'b1, 1'b0); expect_char("R4 msb 8N", 9'h0b5, 0, 0, 0);
        // R3 R4: 9 data bits MSB first
        g_m = 1; reconfig();
        send(9'h1c3, 1'b1, 1'b0); expect_char("R4 msb 9N", 9'h1c3, 0, 0, 0);
        g_msb = 0; reconfig();
        send(9'h12a, 1'b1, 1'b0); expect_char("R3 9N", 9'h12a, 0, 0, 0);
        // R2: ten-bit select ignored without parity
        g_ten = 1; g_m = 0; reconfig();
        send(9'h1ff, 1'b1, 1'b0); expect_char("R2 ten no parity", 9'h1ff, 0, 0, 0);
        // R2 R6: 10-bit frame with odd parity, then a flipped parity bit
        g_pe = 1; g_odd = 1; reconfig();
        send(9'h155, 1'b1, 1'b0); expect_char("R2 10-bit", 9'h155, 0, 0, 0);
        send(9'h155, 1'b1, 1'b1); expect_char("R6 parity", 9'h155, 0, 1, 0);
        // R2: 7 data bits with even parity
        g_ten = 0; g_odd = 0; reconfig();
        send(9'h0ff, 1'b1, 1'b0); expect_char("R2 7E", 9'h0ff, 0, 0, 0);
        // R6: framing error
        g_pe = 0; reconfig();
        send(9'h03c, 1'b0, 1'b0); expect_char("R6 framing", 9'h03c, 1, 0, 0);
        // R8: overrun keeps first
        send(9'h011, 1'b1, 1'b0);
        send(9'h0ee, 1'b1, 1'b0);
        expect_char("R8 overrun", 9'h011, 0, 0, 1);
        // R5: start glitch rejected
        set_line(1'b0); wait_clk(3 * int'(g_div));
        set_line(1'b1); wait_clk(3 * bitlen());
        check("R5 glitch no valid", rd_valid, 1'b0);
        check("R5 glitch no flags", {rd_fe, rd_pe, rd_ov}, 3'b000);
        send(9'h0a7, 1'b1, 1'b0); expect_char("R5 after glitch", 9'h0a7, 0, 0, 0);
        // R9: divisor zero stops reception
        g_div = 0; wait_clk(4);
        for (int i = 0; i < 12; i++) begin
            set_line(i[0]); wait_clk(64);
        end
        set_line(1'b1); wait_clk(64);
        check("R9 div zero no valid", rd_valid, 1'b0);
        g_div = 3; g_frac = 5'd30; reconfig();
        send(9'h069, 1'b1, 1'b0); expect_char("R9 fractional", 9'h069, 0, 0, 0);
        // R10: inverted line
        g_inv = 1; reconfig();
        send(9'h0c4, 1'b1, 1'b0); expect_char("R10 inverted", 9'h0c4, 0, 0, 0);
        // R11: loop sources, and pin ignored in loop mode
        g_inv = 0; g_frac = 0; g_route = 1; reconfig();
        send(9'h05a, 1'b1, 1'b0); expect_char("R11 internal loop", 9'h05a, 0, 0, 0);
        drv_sel = 0;
        send(9'h0f0, 1'b1, 1'b0);
        check("R11 pin ignored valid", rd_valid, 1'b0);
        g_route = 2; reconfig();
        send(9'h0a5, 1'b1, 1'b0); expect_char("R11 pin loop", 9'h0a5, 0, 0, 0);

        // random formats
        for (int k = 0; k < 24; k++) begin
            logic [8:0] w;
            g_m = 1'($urandom); g_ten = 1'($urandom); g_pe = 1'($urandom);
            g_odd = 1'($urandom); g_msb = 1'($urandom); g_inv = 1'($urandom);
            g_route = int'($urandom % 3);
            g_div = 13'(2 + $urandom % 3);
            g_frac = 5'(2 * ($urandom % 16));
            reconfig();
            w = 9'($urandom);
            send(w, 1'b1, 1'b0);
            expect_char("R2 R4 R10 R11 random", w, 0, 0, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule